// File: doc/BRIEF.md
# Indirect Register Mailbox Bridge

This block sits behind a byte-wide host bus and exposes only three physical byte locations. One reports handshake state, one takes bytes from the host, and one returns a fetched byte. Through them the host reaches a larger file of virtual byte registers. The file itself lives outside the block and is reached through a single-cycle strobe port.

The host first checks that the inbound slot is free. It then writes an address byte. If the top bit of that byte is set, the byte opens a write: the next byte accepted is taken as data for the register named by the lower seven bits. If the top bit is clear, the byte asks for a read. The block fetches the addressed byte, places it in the return location and raises a flag. Reading the return location lowers that flag again.

Each accepted byte is consumed after a fixed, parameterised number of cycles, and the busy flag stays up for exactly that window. Virtual addresses at or above the mapped depth never strobe the external file. A read of such an address returns zero.

Top module: `vreg_mailbox`

## Requirements
- R1: Host location 0 returns STATUS, with the busy flag (byte not yet consumed) in bit 1, the fresh-data flag in bit 0 and zeros elsewhere; location 2 returns the READ byte; locations 1 and 3 read as 0x00.
- R2: After reset both flags are 0, READ holds 0x00 and no virtual strobe is issued.
- R3: A host write to location 1 while the busy flag is 0 is accepted and sets the busy flag for exactly CONSUME_CYC cycles, after which the flag returns to 0.
- R4: A host write to location 1 while the busy flag is 1 is ignored and does not alter the sequence in progress.
- R5: A consumed byte with bit 7 set and no write pending only latches bits 6:0 as the target and issues no strobe; the next consumed byte produces exactly one write strobe to that target, carrying that byte.
- R6: A consumed byte with bit 7 clear and no write pending produces exactly one read strobe, loads READ with the returned byte and sets the fresh-data flag.
- R7: A host read of location 2 clears the fresh-data flag.
- R8: The byte that follows a write-address byte is treated as data even when its bit 7 is 1.
- R9: A virtual address at or above VR_DEPTH produces no strobe; a read of it loads 0x00 into READ and still sets the fresh-data flag, and a write to it is discarded.
- R10: Host writes to locations 0, 2 and 3 have no effect on either flag, on READ or on the virtual file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 for a host write, 0 for a host read |
| host_addr | input | 2 | Physical location select |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte at the selected location (combinational) |
| vr_wr | output | 1 | Virtual write strobe |
| vr_rd | output | 1 | Virtual read strobe |
| vr_addr | output | 7 | Virtual register address |
| vr_wdata | output | 8 | Virtual write byte |
| vr_rdata | input | 8 | Virtual read byte, valid in the cycle of vr_rd |

## Verification
A stale write-pending marker would turn the next address byte into data. The host would see this at once: the following read-back returns the wrong byte, and the strobe count differs on the very next consume. A miscounted consume window shows up as a busy flag that stays up for a different number of cycles than CONSUME_CYC. A fresh-data flag that fails to clear or set is visible on STATUS one cycle after the access that should have changed it. An unmapped-address filter that leaks produces a strobe the bench counts, and a nonzero read-back.

// File: rtl/vmb_pkg.sv
package vmb_pkg;
   typedef enum logic [1:0] {
      HLOC_STATUS = 2'd0,
      HLOC_INBOX  = 2'd1,
      HLOC_RETURN = 2'd2,
      HLOC_SPARE  = 2'd3
   } hloc_e;

   localparam int FLAG_BUSY_BIT  = 1;
   localparam int FLAG_FRESH_BIT = 0;
endpackage

// File: rtl/vmb_byte_engine.sv
module vmb_byte_engine #(
   parameter int DW          = 8,
   parameter int CONSUME_CYC = 4,
   parameter int VR_DEPTH    = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_byte,
   output logic          busy,
   output logic          fetch_pulse,
   output logic          fetch_hit,
   output logic          vr_wr,
   output logic          vr_rd,
   output logic [DW-2:0] vr_addr,
   output logic [DW-1:0] vr_wdata
);
   localparam int AW     = DW - 1;
   localparam int CW     = $clog2(CONSUME_CYC + 1);
   localparam int SPAN   = 2 ** AW;

   generate
      if (CONSUME_CYC < 1) begin : g_bad_cyc
         $error("CONSUME_CYC must be at least 1");
      end
      if (VR_DEPTH < 1 || VR_DEPTH > SPAN) begin : g_bad_depth
         $error("VR_DEPTH out of range for address width");
      end
   endgenerate

   logic [DW-1:0] byte_q;
   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic          pend_q;
   logic [AW-1:0] pend_addr_q;
   logic          consume;
   logic          take_data;
   logic          take_waddr;
   logic          take_raddr;
   logic [AW-1:0] tgt_addr;
   logic          hit;

   assign consume    = busy_q && (cnt_q == '0);
   assign take_data  = pend_q;
   assign take_waddr = !pend_q && byte_q[DW-1];
   assign take_raddr = !pend_q && !byte_q[DW-1];
   assign tgt_addr   = pend_q ? pend_addr_q : byte_q[AW-1:0];

   generate
      if (VR_DEPTH >= SPAN) begin : g_full_map
         assign hit = 1'b1;
      end else begin : g_part_map
         assign hit = (32'(tgt_addr) < VR_DEPTH);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         byte_q      <= '0;
         cnt_q       <= '0;
         busy_q      <= 1'b0;
         pend_q      <= 1'b0;
         pend_addr_q <= '0;
      end else begin
         if (push) begin
            byte_q <= push_byte;
            cnt_q  <= CW'(CONSUME_CYC - 1);
            busy_q <= 1'b1;
         end else if (consume) begin
            busy_q <= 1'b0;
            if (take_data) begin
               pend_q <= 1'b0;
            end else if (take_waddr) begin
               pend_q      <= 1'b1;
               pend_addr_q <= byte_q[AW-1:0];
            end
         end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign busy        = busy_q;
   assign fetch_pulse = consume && take_raddr;
   assign fetch_hit   = hit;
   assign vr_wr       = consume && take_data && hit;
   assign vr_rd       = consume && take_raddr && hit;
   assign vr_addr     = tgt_addr;
   assign vr_wdata    = byte_q;

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(vr_wr && vr_rd)); // R5
   AST_PUSH_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !busy_q); // R4
   AST_PUSH_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> busy_q); // R3
   AST_STROBE_IN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      (vr_wr || vr_rd) |-> (32'(vr_addr) < VR_DEPTH)); // R9
endmodule

// File: rtl/vmb_host_port.sv
module vmb_host_port
   import vmb_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_sel,
   input  logic          host_wr,
   input  logic [1:0]    host_addr,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata,
   input  logic          busy,
   input  logic          fetch_pulse,
   input  logic          fetch_hit,
   input  logic [DW-1:0] vr_rdata,
   output logic          push,
   output logic [DW-1:0] push_byte,
   output logic          fresh
);
   logic [DW-1:0] ret_q;
   logic          fresh_q;
   logic          rd_return;
   hloc_e         loc;

   assign loc       = hloc_e'(host_addr);
   assign push      = host_sel && host_wr && (loc == HLOC_INBOX) && !busy;
   assign push_byte = host_wdata;
   assign rd_return = host_sel && !host_wr && (loc == HLOC_RETURN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ret_q   <= '0;
         fresh_q <= 1'b0;
      end else if (fetch_pulse) begin
         ret_q   <= fetch_hit ? vr_rdata : '0;
         fresh_q <= 1'b1;
      end else if (rd_return) begin
         fresh_q <= 1'b0;
      end
   end

   always_comb begin
      host_rdata = '0;
      case (loc)
         HLOC_STATUS: begin
            host_rdata[FLAG_BUSY_BIT]  = busy;
            host_rdata[FLAG_FRESH_BIT] = fresh_q;
         end
         HLOC_RETURN: host_rdata = ret_q;
         default:     host_rdata = '0;
      endcase
   end

   assign fresh = fresh_q;

   AST_FETCH_SETS_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_pulse |=> fresh_q); // R6
   AST_RETURN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_return && !fetch_pulse) |=> !fresh_q); // R7
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_pulse && !fetch_hit) |=> (ret_q == '0)); // R9
endmodule

// File: rtl/vreg_mailbox.sv
module vreg_mailbox #(
   parameter int DW          = 8,
   parameter int CONSUME_CYC = 4,
   parameter int VR_DEPTH    = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_sel,
   input  logic          host_wr,
   input  logic [1:0]    host_addr,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata,
   output logic          vr_wr,
   output logic          vr_rd,
   output logic [DW-2:0] vr_addr,
   output logic [DW-1:0] vr_wdata,
   input  logic [DW-1:0] vr_rdata
);
   logic          busy;
   logic          push;
   logic [DW-1:0] push_byte;
   logic          fetch_pulse;
   logic          fetch_hit;
   logic          fresh;

   vmb_host_port #(.DW(DW)) u_port (
      .clk(clk), .rst_n(rst_n),
      .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .busy(busy), .fetch_pulse(fetch_pulse), .fetch_hit(fetch_hit),
      .vr_rdata(vr_rdata), .push(push), .push_byte(push_byte), .fresh(fresh)
   );

   vmb_byte_engine #(.DW(DW), .CONSUME_CYC(CONSUME_CYC), .VR_DEPTH(VR_DEPTH)) u_engine (
      .clk(clk), .rst_n(rst_n),
      .push(push), .push_byte(push_byte), .busy(busy),
      .fetch_pulse(fetch_pulse), .fetch_hit(fetch_hit),
      .vr_wr(vr_wr), .vr_rd(vr_rd), .vr_addr(vr_addr), .vr_wdata(vr_wdata)
   );

   AST_FRESH_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      vr_rd |=> fresh); // R6
   AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(vr_wr || vr_rd)); // R2
endmodule

// File: tb/vreg_mailbox_bench.sv
module vreg_mailbox_bench;
   localparam int CYC   = 4;
   localparam int DEPTH = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_sel = 1'b0;
   logic       host_wr = 1'b0;
   logic [1:0] host_addr = 2'd0;
   logic [7:0] host_wdata = 8'd0;
   logic [7:0] host_rdata;
   logic       vr_wr, vr_rd;
   logic [6:0] vr_addr;
   logic [7:0] vr_wdata;
   logic [7:0] vr_rdata;

   logic [7:0] vmem    [0:127];
   logic [7:0] exp_mem [0:127];
   int n_cmp = 0;
   int n_bad = 0;
   int wr_cnt = 0;
   int rd_cnt = 0;

   always #10 clk = ~clk;

   vreg_mailbox #(.DW(8), .CONSUME_CYC(CYC), .VR_DEPTH(DEPTH)) u_vreg_mailbox (
      .clk(clk), .rst_n(rst_n),
      .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .vr_wr(vr_wr), .vr_rd(vr_rd), .vr_addr(vr_addr),
      .vr_wdata(vr_wdata), .vr_rdata(vr_rdata)
   );

   assign vr_rdata = vmem[vr_addr];

   always @(posedge clk) begin
      if (vr_wr) begin
         vmem[vr_addr] <= vr_wdata;
         wr_cnt <= wr_cnt + 1;
      end
      if (vr_rd) rd_cnt <= rd_cnt + 1;
   end

   function automatic logic [7:0] model_read(input logic [6:0] a);
      return (int'(a) < DEPTH) ? exp_mem[a] : 8'h00;
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hwr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_sel = 1'b0; host_wr = 1'b0; host_addr = 2'd0;
      #1;
   endtask

   task automatic hrd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
      #1 d = host_rdata;
      @(negedge clk);
      host_sel = 1'b0; host_addr = 2'd0;
      #1;
   endtask

   task automatic wait_idle();
      logic [7:0] s;
      for (int i = 0; i < 50; i++) begin
         hrd(2'd0, s);
         if (!s[1]) break;
      end
   endtask

   task automatic vwrite(input logic [6:0] a, input logic [7:0] d);
      wait_idle();
      hwr(2'd1, {1'b1, a});
      wait_idle();
      hwr(2'd1, d);
      wait_idle();
      if (int'(a) < DEPTH) exp_mem[a] = d;
   endtask

   task automatic vread(input logic [6:0] a, output logic [7:0] d);
      logic [7:0] s;
      wait_idle();
      hwr(2'd1, {1'b0, a});
      for (int i = 0; i < 50; i++) begin
         hrd(2'd0, s);
         if (s[0]) break;
      end
      hrd(2'd2, d);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] d, s;
      int w0, r0, n;
      for (int i = 0; i < 128; i++) begin
         vmem[i]    = 8'(i) ^ 8'hA5;
         exp_mem[i] = 8'(i) ^ 8'hA5;
      end
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;

      // R2 reset state
      hrd(2'd0, s); chk("R2 status", s, 8'h00);
      hrd(2'd2, d); chk("R2 return", d, 8'h00);
      chk("R2 strobes", 8'(wr_cnt + rd_cnt), 8'h00);
      // R1 unused locations
      hrd(2'd1, d); chk("R1 loc1", d, 8'h00);
      hrd(2'd3, d); chk("R1 loc3", d, 8'h00);

      // R3 busy window, R5 address byte strobes nothing
      w0 = wr_cnt;
      hwr(2'd1, 8'h81);
      n = 0;
      while (host_rdata[1] && n < 100) begin
         n++;
         @(negedge clk); #1;
      end
      chk("R3 busy cycles", 8'(n), 8'(CYC));
      chk("R5 no strobe on address", 8'(wr_cnt - w0), 8'h00);
      // R8 data byte with bit7 set
      hwr(2'd1, 8'hC3);
      wait_idle();
      exp_mem[1] = 8'hC3;
      chk("R5 one write strobe", 8'(wr_cnt - w0), 8'h01);
      vread(7'd1, d); chk("R8 data with top bit", d, 8'hC3);

      // R4 ignored write during busy
      w0 = wr_cnt;
      wait_idle();
      hwr(2'd1, 8'h85);
      hwr(2'd1, 8'h33);
      wait_idle();
      hwr(2'd1, 8'h5A);
      wait_idle();
      exp_mem[5] = 8'h5A;
      chk("R4 strobe count", 8'(wr_cnt - w0), 8'h01);
      vread(7'd5, d); chk("R4 data intact", d, 8'h5A);

      // R6 read strobe and fresh flag, R7 clear
      r0 = rd_cnt;
      wait_idle();
      hwr(2'd1, 8'h09);
      wait_idle();
      hrd(2'd0, s); chk("R6 fresh set", s, 8'h01);
      chk("R6 one read strobe", 8'(rd_cnt - r0), 8'h01);
      hrd(2'd2, d); chk("R6 return byte", d, model_read(7'd9));
      hrd(2'd0, s); chk("R7 fresh cleared", s, 8'h00);

      // R9 unmapped
      w0 = wr_cnt; r0 = rd_cnt;
      vwrite(7'd100, 8'h77);
      chk("R9 no write strobe", 8'(wr_cnt - w0), 8'h00);
      vread(7'd100, d); chk("R9 read zero", d, 8'h00);
      chk("R9 no read strobe", 8'(rd_cnt - r0), 8'h00);
      vread(7'd127, d); chk("R9 top address zero", d, 8'h00);

      // R10 writes to other locations
      vread(7'd9, d);
      w0 = wr_cnt;
      hwr(2'd2, 8'hFF); hwr(2'd0, 8'hFF); hwr(2'd3, 8'hFF);
      hrd(2'd0, s); chk("R10 status", s, 8'h00);
      hrd(2'd2, s); chk("R10 return kept", s, d);
      chk("R10 no strobe", 8'(wr_cnt - w0), 8'h00);

      // random mix (R5 R6 R9)
      for (int k = 0; k < 120; k++) begin
         logic [6:0] a;
         logic [7:0] v;
         a = 7'($urandom_range(0, 127));
         v = 8'($urandom);
         if ($urandom_range(0, 1) == 1) begin
            vwrite(a, v);
         end else begin
            vread(a, d);
            chk("R6 random read", d, model_read(a));
         end
      end
      for (int i = 0; i < DEPTH; i += 7) begin
         vread(7'(i), d);
         chk("R5 sweep readback", d, model_read(7'(i)));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule